// File: doc/BRIEF.md
# Grouped Shared Interrupt Aggregator

This block gathers 22 peripheral interrupt sources into one 32-bit pending word and splits that word into four fixed groups of adjacent bits. Each group drives its own parent interrupt line. A line stays high while any pending bit in its group is set and not masked.

A rising level on a source latches its pending bit. The bit stays set until software clears it. Software reads the pending word and clears bits at a single word address, using a read-modify-write that writes 0 only to the bits it wants to clear. Only the lowest group can be masked, and its mask is active-low: a 1 masks the source and a 0 lets it through.

The register port is plain: read strobe, write strobe, word address and 32-bit data. It has no handshake, so every access completes in the cycle it is presented. Read data is combinational from the current state.

Top module: `shirq_aggregator`

## Requirements
- R1: A rising level on `src_i[i]` (high now, low at the previous clock) sets pending bit i at the next clock edge. The bit then stays set until a clear removes it.
- R2: A write to word address 1 (byte offset 0x04) clears pending bit i when `reg_wdata[i]` is 0. When the bit is 1, the pending bit is unchanged.
- R3: If a set and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R4: Pending bits latch whether or not their source is masked. The mask gates only the group's output line.
- R5: Word address 2 (byte offset 0x08) holds the mask of the low group in bits [6:0], one bit per source 0..6. A bit value of 1 masks the source and 0 enables it.
- R6: `irq_o[0]` is the OR of unmasked pending bits 0..6. `irq_o[1]` is the OR of pending bits 7..9, `irq_o[2]` is pending bit 10 and `irq_o[3]` is the OR of pending bits 11..21. Each line changes in the same cycle as the pending bits.
- R7: After a partial clear, a group line stays high as long as any pending bit in its range is still set.
- R8: Pending bits 22..31 and mask bits 7..31 read as 0, and writes to them are ignored. Word addresses other than 1 and 2 read as 0, and writes to them change nothing.
- R9: After reset, all pending bits are 0, the mask reads 0x7F and all group lines are low.
- R10: `reg_rdata` is 0 while `reg_re` is low. Reads never change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 22 | Peripheral interrupt levels |
| reg_re | input | 1 | Read strobe |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq_o | output | 4 | Parent interrupt line per group |

## Verification
On every clock, the assertions check:
- that pending bits are sticky outside status writes;
- that edges always set their bits, with set taking priority over clear;
- that written zeros clear their bits;
- that a fully masked low group keeps its line low;
- that unused read bits are zero.

The grouping boundaries, the active-low mask polarity, partial clears and reads at invalid addresses are shown only by the bench. It drives directed scenarios and random traffic, and compares each access against a reference model.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int NSRC      = 22;
  localparam int NGRP      = 4;
  localparam int MASK_W    = 7;
  localparam int STAT_WORD = 1;
  localparam int MASK_WORD = 2;
  localparam int GRP_LO [NGRP] = '{0, 7, 10, 11};
  localparam int GRP_W  [NGRP] = '{7, 3, 1, 11};
  localparam logic [NGRP-1:0] GRP_MASKABLE = 4'b0001;
endpackage

// File: rtl/shirq_pending.sv
module shirq_pending
  import shirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         clr_wr,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] src_q,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] rise;
  logic [N-1:0] pend_d;

  always_comb begin
    rise   = src_i & ~src_q;
    pend_d = clr_wr ? (pend_q & keep_i) : pend_q;
    pend_d = pend_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/shirq_mask_reg.sv
module shirq_mask_reg
  import shirq_pkg::*;
#(
  parameter int W = MASK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_n_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_n_q <= '1;
    else if (wr_i) mask_n_q <= wdata_i;
  end
endmodule

// File: rtl/shirq_group_or.sv
module shirq_group_or
  import shirq_pkg::*;
#(
  parameter int LO       = 0,
  parameter int W        = 1,
  parameter bit MASKABLE = 1'b0
) (
  input  logic [NSRC-1:0]   pend_i,
  input  logic [MASK_W-1:0] mask_n_i,
  output logic              irq_o
);
  logic [W-1:0] live;

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (MASKABLE && (k < MASK_W)) begin : g_gated
      assign live[k] = pend_i[LO+k] & ~mask_n_i[k];
    end else begin : g_open
      assign live[k] = pend_i[LO+k];
    end
  end

  assign irq_o = |live;
endmodule

// File: rtl/shirq_regif.sv
module shirq_regif
  import shirq_pkg::*;
(
  input  logic              reg_re,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   pend_i,
  input  logic [MASK_W-1:0] mask_n_i,
  output logic              clr_wr_o,
  output logic [NSRC-1:0]   keep_o,
  output logic              mask_wr_o,
  output logic [MASK_W-1:0] mask_wdata_o,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int STAT_PAD = DATA_W - NSRC;
  localparam int MASK_PAD = DATA_W - MASK_W;

  logic hit_stat;
  logic hit_mask;

  assign hit_stat     = (reg_addr == ADDR_W'(STAT_WORD));
  assign hit_mask     = (reg_addr == ADDR_W'(MASK_WORD));
  assign clr_wr_o     = reg_we & hit_stat;
  assign keep_o       = reg_wdata[NSRC-1:0];
  assign mask_wr_o    = reg_we & hit_mask;
  assign mask_wdata_o = reg_wdata[MASK_W-1:0];

  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      if (hit_stat)      reg_rdata = {{STAT_PAD{1'b0}}, pend_i};
      else if (hit_mask) reg_rdata = {{MASK_PAD{1'b0}}, mask_n_i};
    end
  end
endmodule

// File: rtl/shirq_aggregator.sv
module shirq_aggregator
  import shirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_re,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NGRP-1:0]   irq_o
);
  logic [NSRC-1:0]   src_q;
  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   keep;
  logic              clr_wr;
  logic              mask_wr;
  logic [MASK_W-1:0] mask_wdata;
  logic [MASK_W-1:0] mask_n_q;

  shirq_regif u_regif (
    .reg_re      (reg_re),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .pend_i      (pend_q),
    .mask_n_i    (mask_n_q),
    .clr_wr_o    (clr_wr),
    .keep_o      (keep),
    .mask_wr_o   (mask_wr),
    .mask_wdata_o(mask_wdata),
    .reg_rdata   (reg_rdata)
  );

  shirq_pending #(.N(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .clr_wr(clr_wr),
    .keep_i(keep),
    .src_q (src_q),
    .pend_q(pend_q)
  );

  shirq_mask_reg #(.W(MASK_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr),
    .wdata_i (mask_wdata),
    .mask_n_q(mask_n_q)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    shirq_group_or #(
      .LO      (GRP_LO[g]),
      .W       (GRP_W[g]),
      .MASKABLE(GRP_MASKABLE[g])
    ) u_or (
      .pend_i  (pend_q),
      .mask_n_i(mask_n_q),
      .irq_o   (irq_o[g])
    );
  end
endmodule

// File: rtl/shirq_aggregator_chk.sv
module shirq_aggregator_chk
  import shirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_i,
  input logic [NSRC-1:0]   src_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [MASK_W-1:0] mask_n_q,
  input logic              reg_re,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NGRP-1:0]   irq_o
);
  logic stat_wr;
  assign stat_wr = reg_we && (reg_addr == ADDR_W'(STAT_WORD));

  // R1: pending bits only fall through a status write
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(stat_wr)) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R2: zeros written to the status word clear bits without a new edge
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stat_wr)) |->
      ((pend_q & ~$past(reg_wdata[NSRC-1:0]) & ~$past(src_i & ~src_q)) == '0));

  // R3: an edge always lands, even against a clear
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & $past(src_i & ~src_q)) == $past(src_i & ~src_q)));

  // R5: a fully masked low group keeps its line low
  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_n_q) |-> !irq_o[0]);

  // R6: nothing pending means no line high
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (irq_o == '0));

  // R8: unused status bits read zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == ADDR_W'(STAT_WORD)) |-> (reg_rdata[DATA_W-1:NSRC] == '0));

  // R10: idle read port returns zero
  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |-> (reg_rdata == '0));
endmodule

bind shirq_aggregator shirq_aggregator_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_i    (src_i),
  .src_q    (src_q),
  .pend_q   (pend_q),
  .mask_n_q (mask_n_q),
  .reg_re   (reg_re),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .irq_o    (irq_o)
);

// File: tb/tb_shirq_aggregator.sv
module tb_shirq_aggregator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] src_i = '0;
  logic        reg_re = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [21:0] m_pend = '0;
  logic [21:0] m_prev = '0;
  logic [6:0]  m_mask = 7'h7F;

  shirq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_re(reg_re), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] exp_irq(logic [21:0] p, logic [6:0] m);
    return {|p[21:11], p[10], |p[9:7], |(p[6:0] & ~m)};
  endfunction

  function automatic logic [31:0] exp_read(logic re, logic [3:0] a, logic [21:0] p, logic [6:0] m);
    if (!re) return '0;
    if (a == 4'd1) return {10'b0, p};
    if (a == 4'd2) return {25'b0, m};
    return '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge: drive, check read, clock, check lines.
  task automatic step(string req, logic [21:0] s, logic we, logic re,
                      logic [3:0] a, logic [31:0] d);
    logic [21:0] rise;
    src_i = s; reg_we = we; reg_re = re; reg_addr = a; reg_wdata = d;
    #1;
    if (re) check(req, reg_rdata, exp_read(re, a, m_pend, m_mask));
    else    check("R10", reg_rdata, 32'h0);
    @(posedge clk);
    rise = s & ~m_prev;
    if (we && a == 4'd1) m_pend = (m_pend & d[21:0]) | rise;
    else                 m_pend = m_pend | rise;
    m_prev = s;
    if (we && a == 4'd2) m_mask = d[6:0];
    @(negedge clk);
    check(req, {28'b0, irq_o}, {28'b0, exp_irq(m_pend, m_mask)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", {28'b0, irq_o}, 32'h0);
    step("R9", '0, 0, 1, 4'd1, 0);
    step("R9", '0, 0, 1, 4'd2, 0);
    // R1 R4: masked group A source still latches, line stays low
    step("R4", 22'h000001, 0, 0, 0, 0);
    step("R4", 22'h000000, 0, 1, 4'd1, 0);
    // R5: enable bit 0 (write 0 there)
    step("R5", 22'h0, 1, 0, 4'd2, 32'h7E);
    step("R5", 22'h0, 0, 1, 4'd2, 0);
    // R6 groups B, C, D
    step("R6", 22'h000080, 0, 0, 0, 0);
    step("R6", 22'h000480, 0, 0, 0, 0);
    step("R6", 22'h200480, 0, 1, 4'd1, 0);
    // R7: partial clear of bit 7, keep bit 8
    step("R7", 22'h0, 0, 0, 0, 0);
    step("R7", 22'h000100, 0, 0, 0, 0);
    step("R7", 22'h0, 1, 0, 4'd1, ~32'h80);
    step("R7", 22'h0, 0, 1, 4'd1, 0);
    // R2: clear everything
    step("R2", 22'h0, 1, 0, 4'd1, 32'h0);
    step("R2", 22'h0, 0, 1, 4'd1, 0);
    // R3: edge and clear together
    step("R3", 22'h000400, 1, 0, 4'd1, 32'h0);
    step("R3", 22'h000400, 0, 1, 4'd1, 0);
    // R8: upper bits, invalid addresses
    step("R8", 22'h0, 1, 0, 4'd2, 32'hFFFF_FF80);
    step("R8", 22'h0, 0, 1, 4'd2, 0);
    step("R8", 22'h0, 1, 0, 4'd3, 32'h0);
    step("R8", 22'h0, 0, 1, 4'd3, 0);
    step("R8", 22'h0, 1, 0, 4'd0, 32'h0);
    step("R8", 22'h0, 0, 1, 4'd1, 0);
    // R1 random traffic with R2/R5 writes mixed in
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic we;
      a  = ($urandom % 4 == 0) ? 4'($urandom) : 4'(1 + $urandom % 2);
      we = ($urandom % 3) == 0;
      step("R1", 22'($urandom & $urandom), we, 1'($urandom), a, $urandom | $urandom);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule